// File: doc/BRIEF.md
# Loadable 64-bit Synchronization Timer

This block keeps the microsecond time base that a wireless MAC uses for timing synchronization. A 64-bit counter advances by one on every clock cycle in which the one-microsecond tick strobe is high. Software sees the block through a small register port. A single write port carries an address and a 32-bit data word. A single read port returns one 32-bit word, one cycle after the request.

Software sets a new time in two steps. First it writes the lower 32 bits into a low staging register. Then it writes the upper bits into a high staging register, in bit positions 30 to 0. These writes leave the running count alone. The count is replaced only when a write to the high staging register clears its bit 31 while that bit was set. The usual sequence is therefore: write the low word, write the high word with bit 31 set, then write the high word again with bit 31 clear.

Software reads the live count as two words. A read of the low word also captures the high word at the same moment. A following read of the high word then returns the matching half, even if a carry has crossed word 0 in between.

Top module: `tsf_timer`

## Requirements
- R1: While no reload takes place, the count rises by exactly one at each rising clock edge where `tick_i` is high, and holds otherwise.
- R2: A write to address 0 (low staging register) stores the data word and never changes the count.
- R3: A write to address 1 (high staging register) with data bit 31 at 0, while the stored bit 31 is 1, reloads the count at that edge. The new value is {1'b0, data[30:0], low staging register}.
- R4: A write to address 1 that does not take stored bit 31 from 1 to 0 stores the data and leaves the count unchanged. This covers data bit 31 at 1, and also stored bit 31 already at 0.
- R5: Addresses 2 (count low word) and 3 (count high word) are read-only, and writes to them have no effect. Reads of addresses 0 and 1 return zero.
- R6: When a reload and a tick fall on the same edge, the count takes the reloaded value exactly, with no increment.
- R7: A read of address 2 returns count bits 31:0 as they stood at the read edge, and captures count bits 63:32 at that same edge. A read of address 3 returns that captured word. Read data appears on `rd_data_o` one cycle after the request and holds until the next read.
- R8: Synchronous active-high reset clears the count, both staging registers, the captured high word and `rd_data_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-microsecond advance strobe, one cycle wide |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address (0 low stage, 1 high stage) |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 2 | Read address (2 count low, 3 count high) |
| rd_data_o | output | 32 | Registered read data |

## Verification
The hardest situation to reach from the ports is a two-part read that straddles a carry out of the low word. The bench reaches it in three steps. It loads a value two below a low-word wrap with the tick held off. It then ticks once. Finally it issues the low-word read in the same cycle as one more tick, so the carry lands exactly on the capture edge. The high-word read that follows must still return the old high word, and a fresh read pair must return the incremented one. A second hard case is a reload that coincides with a tick. The bench drives both in one cycle and checks for the exact loaded value.

// File: rtl/tsf_timer_pkg.sv
package tsf_timer_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAGE_LO = 2'd0,
    SEL_STAGE_HI = 2'd1,
    SEL_COUNT_LO = 2'd2,
    SEL_COUNT_HI = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tsf_stage.sv
module tsf_stage
  import tsf_timer_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o
);
  logic [WORD_W-1:0] lo_q;
  logic [WORD_W-1:0] hi_q;
  logic              wr_lo;
  logic              wr_hi;

  assign wr_lo = wr_en_i && (wr_addr_i == SEL_STAGE_LO);
  assign wr_hi = wr_en_i && (wr_addr_i == SEL_STAGE_HI);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wr_data_i;
      if (wr_hi) hi_q <= wr_data_i;
    end
  end

  // Reload fires when the stored top bit is set and this write clears it.
  assign load_o     = wr_hi && hi_q[WORD_W-1] && !wr_data_i[WORD_W-1];
  assign load_val_o = {1'b0, wr_data_i[WORD_W-2:0], lo_q};

  // R4: a write whose data keeps bit 31 set can never trigger a reload
  a_r4_set_msb_no_load: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_hi && wr_data_i[WORD_W-1]) |-> !load_o);

  // R2: a write to the low stage register is never a reload cycle
  a_r2_low_write_no_load: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_lo |-> !load_o);
endmodule

// File: rtl/tsf_counter.sv
module tsf_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R1: with no reload and no tick the count holds
  a_r1_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !tick_i) |=> $stable(cnt_o));

  // R6: a reload wins over a simultaneous tick
  a_r6_load_priority: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && tick_i) |=> (cnt_o == $past(load_val_i)));
endmodule

// File: rtl/tsf_readback.sv
module tsf_readback
  import tsf_timer_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] snap_hi_q;
  logic [WORD_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      snap_hi_q <= '0;
      rd_q      <= '0;
    end else if (rd_en_i) begin
      unique case (reg_sel_e'(rd_addr_i))
        SEL_COUNT_LO: begin
          rd_q      <= cnt_i[WORD_W-1:0];
          snap_hi_q <= cnt_i[CNT_W-1:WORD_W];
        end
        SEL_COUNT_HI: rd_q <= snap_hi_q;
        default:      rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;

  // R7: read data holds between reads
  a_r7_hold_between_reads: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/tsf_timer.sv
module tsf_timer
  import tsf_timer_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int unsigned CNT_W = 2 * WORD_W;

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;

  tsf_stage #(.WORD_W(WORD_W)) stage_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .load_o     (load),
    .load_val_o (load_val)
  );

  tsf_counter #(.CNT_W(CNT_W)) counter_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt)
  );

  tsf_readback #(.WORD_W(WORD_W)) readback_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .cnt_i     (cnt),
    .rd_data_o (rd_data_o)
  );

  // R2: a low stage write only lets the tick move the count
  a_r2_low_write_keeps_count: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == SEL_STAGE_LO && !tick_i) |=> $stable(cnt));

  // R5: writes to the read-only count words leave the count alone
  a_r5_ro_write_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i[1] && !tick_i) |=> $stable(cnt));

  // R3: after a reload the top count bit is zero and the high half matches data[30:0]
  a_r3_reload_shape: assert property (@(posedge clk_i) disable iff (rst_i)
    load |=> (cnt[CNT_W-1] == 1'b0 &&
              cnt[CNT_W-2:WORD_W] == $past(wr_data_i[WORD_W-2:0])));

  // R7: a low word read returns the count as it stood at the read edge
  a_r7_low_read_value: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && rd_addr_i == SEL_COUNT_LO) |=> (rd_data_o == $past(cnt[WORD_W-1:0])));
endmodule

// File: tb/tsf_timer_tb.sv
module tsf_timer_tb_top;
  import tsf_timer_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  tsf_timer #(.WORD_W(32)) dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; tick = tk;
    @(negedge clk);
    rd_en = 1'b0; tick = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check("R8 rd_data after reset", rd_data, 32'h0);
    rd(SEL_COUNT_LO, v); check("R8 count low after reset", v, 32'h0);
    rd(SEL_COUNT_HI, v); check("R8 count high after reset", v, 32'h0);
  endtask

  task automatic t_low_only();
    logic [31:0] v;
    wr(SEL_STAGE_LO, 32'h1234_5678);
    rd(SEL_COUNT_LO, v); check("R2 low write no reload", v, 32'h0);
  endtask

  task automatic t_msb_set();
    logic [31:0] v;
    wr(SEL_STAGE_HI, 32'h8000_0005);
    rd(SEL_COUNT_LO, v); check("R4 set msb no reload lo", v, 32'h0);
    rd(SEL_COUNT_HI, v); check("R4 set msb no reload hi", v, 32'h0);
  endtask

  task automatic t_fall_load();
    logic [31:0] v;
    wr(SEL_STAGE_HI, 32'h0000_0005);
    rd(SEL_COUNT_LO, v); check("R3 reload low word", v, 32'h1234_5678);
    rd(SEL_COUNT_HI, v); check("R3 reload high word", v, 32'h0000_0005);
  endtask

  task automatic t_no_fall();
    logic [31:0] v;
    wr(SEL_STAGE_LO, 32'hAAAA_0000);
    wr(SEL_STAGE_HI, 32'h0000_0009);
    rd(SEL_COUNT_LO, v); check("R4 clear msb again no reload lo", v, 32'h1234_5678);
    rd(SEL_COUNT_HI, v); check("R4 clear msb again no reload hi", v, 32'h0000_0005);
  endtask

  task automatic t_tick();
    logic [31:0] v;
    pulse(10);
    rd(SEL_COUNT_LO, v); check("R1 ten ticks", v, 32'h1234_5682);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(SEL_STAGE_LO, 32'h0000_0100);
    wr(SEL_STAGE_HI, 32'h8000_0000);
    wr(SEL_STAGE_HI, 32'h0000_0002, 1'b1);
    rd(SEL_COUNT_LO, v); check("R6 reload beats tick lo", v, 32'h0000_0100);
    rd(SEL_COUNT_HI, v); check("R6 reload beats tick hi", v, 32'h0000_0002);
  endtask

  task automatic t_carry();
    logic [31:0] v;
    wr(SEL_STAGE_LO, 32'hFFFF_FFFE);
    wr(SEL_STAGE_HI, 32'h8000_0003);
    wr(SEL_STAGE_HI, 32'h0000_0003);
    pulse(1);
    rd(SEL_COUNT_LO, v, 1'b1); check("R7 low read at carry edge", v, 32'hFFFF_FFFF);
    rd(SEL_COUNT_HI, v);       check("R7 captured high before carry", v, 32'h0000_0003);
    rd(SEL_COUNT_LO, v);       check("R7 low after carry", v, 32'h0000_0000);
    rd(SEL_COUNT_HI, v);       check("R7 high after carry", v, 32'h0000_0004);
  endtask

  task automatic t_high_bits();
    logic [31:0] v;
    wr(SEL_STAGE_LO, 32'h0);
    wr(SEL_STAGE_HI, 32'hFFFF_FFFF);
    wr(SEL_STAGE_HI, 32'h7FFF_FFFF);
    rd(SEL_COUNT_LO, v); check("R3 full high field lo", v, 32'h0);
    rd(SEL_COUNT_HI, v); check("R3 full high field hi", v, 32'h7FFF_FFFF);
  endtask

  task automatic t_read_only();
    logic [31:0] v;
    wr(SEL_STAGE_HI, 32'h8000_0001);
    wr(SEL_COUNT_LO, 32'hDEAD_BEEF);
    wr(SEL_COUNT_HI, 32'h0000_0000);
    rd(SEL_COUNT_LO, v); check("R5 ro write lo unchanged", v, 32'h0);
    rd(SEL_COUNT_HI, v); check("R5 ro write hi unchanged", v, 32'h7FFF_FFFF);
    rd(SEL_STAGE_LO, v); check("R5 stage low reads zero", v, 32'h0);
    rd(SEL_STAGE_HI, v); check("R5 stage high reads zero", v, 32'h0);
  endtask

  task automatic t_reset_clears_stage();
    logic [31:0] v;
    do_reset();
    check("R8 rd_data cleared", rd_data, 32'h0);
    wr(SEL_STAGE_LO, 32'h0000_0055);
    wr(SEL_STAGE_HI, 32'h0000_0001);
    rd(SEL_COUNT_LO, v); check("R8 stage msb cleared lo", v, 32'h0);
    rd(SEL_COUNT_HI, v); check("R8 stage msb cleared hi", v, 32'h0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_low_only();
    t_msb_set();
    t_fall_load();
    t_no_fall();
    t_tick();
    t_priority();
    t_carry();
    t_high_bits();
    t_read_only();
    t_reset_clears_stage();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule